// File: doc/BRIEF.md
# Sleep and Standby Power Controller

This block governs the low-power behaviour of a small processor. When the core signals that it has executed its sleep instruction, the controller samples a depth-select bit. With the bit clear it enters a light sleep in which only the CPU clock is gated. With the bit set it enters a deep standby in which the CPU clock, the peripheral clocks and the oscillator are all stopped, the peripherals are held in reset, and the I/O pads either keep their values or float, as a second select bit chooses.

Each depth accepts its own set of wake events. Light sleep ends on any maskable interrupt, a DMA address error, an NMI, a power-on reset or a manual reset. Deep standby ends only on an NMI or a reset. It first restarts the oscillator and waits a fixed number of reference-clock cycles for it to settle. During a reset wake the core reset is held for that wait. Every exit passes through a one-cycle exception-entry pulse that carries a cause code, and only then does the block report normal running. The block runs on an always-on reference clock. The oscillator, the core, the RAM and the interrupt controller are seen only through these enables and request lines.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset the status is 0 (run). The CPU clock, peripheral clock and oscillator enables are 1. The peripheral reset, pad float, reset hold and exception-entry outputs are 0.
- R2: In run, a sleep request with deep_sel_i at 0 gives status 1 (sleep) on the next cycle. The CPU clock enable becomes 0 while the peripheral clock and oscillator enables stay 1 and the peripheral reset stays 0.
- R3: In run, a sleep request with deep_sel_i at 1 gives status 2 (standby) on the next cycle. The CPU clock, peripheral clock and oscillator enables are 0 and the peripheral reset is 1.
- R4: io_hiz_o equals the hiz_sel_i value captured with the standby request, for the whole of standby and settling. It is 0 in run and in sleep.
- R5: In sleep, an interrupt, a DMA address error, an NMI, a power-on reset or a manual reset each end sleep on the next cycle with an exception-entry pulse.
- R6: In standby, interrupts and DMA address errors are ignored: status stays 2 and the oscillator stays off.
- R7: An NMI in standby gives status 3 (settle) on the next cycle, with the oscillator enable 1, both other clock enables 0 and the peripheral reset 1. Status 3 lasts exactly SETTLE_CYCLES cycles, followed by the exception-entry pulse.
- R8: A power-on or manual reset in standby enters settling with rst_hold_o at 1 for all SETTLE_CYCLES cycles. The exception-entry pulse that follows carries cause 3.
- R9: exc_entry_o is high for exactly one cycle per exit, and status returns to 0 on the next cycle. While the pulse is high, exc_cause_o is 0 for an interrupt, 1 for a DMA address error, 2 for an NMI and 3 for a reset. exc_cause_o is 0 at all other times.
- R10: A reset wins over a sleep request in the same cycle, giving a reset exception with no power-down. In sleep the wake priority is reset, then NMI, then interrupt, then DMA address error.
- R11: A sleep request while in sleep, standby or settle has no effect on status or outputs.
- R12: A reset arriving while an NMI settle is under way switches the cause to reset and raises rst_hold_o. The wait is not restarted, so the total settle length stays SETTLE_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| sleep_req_i | input | 1 | Core executed its sleep instruction (one-cycle pulse) |
| deep_sel_i | input | 1 | Depth select: 0 sleep, 1 standby |
| hiz_sel_i | input | 1 | Float the pads during standby when 1 |
| irq_i | input | 1 | Any maskable interrupt pending |
| dma_err_i | input | 1 | DMA address error |
| nmi_i | input | 1 | Non-maskable interrupt |
| por_i | input | 1 | Power-on reset request |
| mrst_i | input | 1 | Manual reset request |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| per_rst_o | output | 1 | Peripheral reinitialisation request |
| io_hiz_o | output | 1 | Pad high-impedance enable |
| rst_hold_o | output | 1 | Hold core in reset during settling |
| exc_entry_o | output | 1 | One-cycle exception-entry pulse |
| exc_cause_o | output | 2 | Cause of the exit, valid with exc_entry_o |
| status_o | output | 2 | 0 run, 1 sleep, 2 standby, 3 settle |

## Verification
A vector table enters each depth and applies one wake pattern at a time: single sources, several sources at once, and none at all. The single sources separate the cause codes. The combined patterns separate the sleep priority order and show that standby filters out interrupts and DMA errors. The empty pattern shows that nothing leaves a state unprompted. Directed tests then cover a reset that coincides with a sleep request, sleep requests repeated while already asleep, and a reset that lands partway through an NMI settle, which shows whether the wait is restarted or carried on.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_STBY   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_EXC    = 3'd4
  } pd_state_e;

  typedef enum logic [1:0] {
    CAUSE_IRQ = 2'd0,
    CAUSE_DMA = 2'd1,
    CAUSE_NMI = 2'd2,
    CAUSE_RST = 2'd3
  } pd_cause_e;

  typedef struct packed {
    logic       cpu_clk_en;
    logic       per_clk_en;
    logic       osc_en;
    logic       per_rst;
    logic       io_hiz;
    logic       rst_hold;
    logic       exc_entry;
    logic [1:0] exc_cause;
    logic [1:0] status;
  } pd_out_t;

endpackage

// File: rtl/pwrdn_rst_sync.sv
module pwrdn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pwrdn_wake_arb.sv
module pwrdn_wake_arb
  import pwrdn_pkg::*;
(
  input  pd_state_e state_i,
  input  logic      irq_i,
  input  logic      dma_err_i,
  input  logic      nmi_i,
  input  logic      rst_req_i,
  output logic      wake_o,
  output pd_cause_e cause_o
);

  // Each state accepts its own set of events; reset always outranks the rest.
  always_comb begin
    wake_o  = 1'b0;
    cause_o = CAUSE_IRQ;
    if (rst_req_i) begin
      wake_o  = 1'b1;
      cause_o = CAUSE_RST;
    end else begin
      unique case (state_i)
        ST_SLEEP: begin
          if (nmi_i) begin
            wake_o  = 1'b1;
            cause_o = CAUSE_NMI;
          end else if (irq_i) begin
            wake_o  = 1'b1;
            cause_o = CAUSE_IRQ;
          end else if (dma_err_i) begin
            wake_o  = 1'b1;
            cause_o = CAUSE_DMA;
          end
        end
        ST_STBY: begin
          if (nmi_i) begin
            wake_o  = 1'b1;
            cause_o = CAUSE_NMI;
          end
        end
        default: begin
          wake_o  = 1'b0;
          cause_o = CAUSE_IRQ;
        end
      endcase
    end
  end

endmodule

// File: rtl/pwrdn_settle_cnt.sv
module pwrdn_settle_cnt #(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);

  localparam int unsigned CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = load_i ? LOAD_VAL : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R7
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == LOAD_VAL));

  // R12
  no_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/pwrdn_out_dec.sv
module pwrdn_out_dec
  import pwrdn_pkg::*;
(
  input  pd_state_e state_i,
  input  pd_cause_e cause_i,
  input  logic      hiz_i,
  output pd_out_t   out_o
);

  always_comb begin
    out_o            = '0;
    out_o.cpu_clk_en = 1'b1;
    out_o.per_clk_en = 1'b1;
    out_o.osc_en     = 1'b1;
    unique case (state_i)
      ST_SLEEP: begin
        out_o.cpu_clk_en = 1'b0;
        out_o.status     = 2'd1;
      end
      ST_STBY: begin
        out_o.cpu_clk_en = 1'b0;
        out_o.per_clk_en = 1'b0;
        out_o.osc_en     = 1'b0;
        out_o.per_rst    = 1'b1;
        out_o.io_hiz     = hiz_i;
        out_o.status     = 2'd2;
      end
      ST_SETTLE: begin
        out_o.cpu_clk_en = 1'b0;
        out_o.per_clk_en = 1'b0;
        out_o.per_rst    = 1'b1;
        out_o.io_hiz     = hiz_i;
        out_o.rst_hold   = (cause_i == CAUSE_RST);
        out_o.status     = 2'd3;
      end
      ST_EXC: begin
        out_o.exc_entry = 1'b1;
        out_o.exc_cause = cause_i;
      end
      default: begin
        out_o.status = 2'd0;
      end
    endcase
  end

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 16,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       deep_sel_i,
  input  logic       hiz_sel_i,
  input  logic       irq_i,
  input  logic       dma_err_i,
  input  logic       nmi_i,
  input  logic       por_i,
  input  logic       mrst_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       osc_en_o,
  output logic       per_rst_o,
  output logic       io_hiz_o,
  output logic       rst_hold_o,
  output logic       exc_entry_o,
  output logic [1:0] exc_cause_o,
  output logic [1:0] status_o
);

  logic      rst_n;
  logic      rst_any;
  logic      wake;
  pd_cause_e wake_cause;
  logic      cnt_zero;
  logic      cnt_load;
  logic      cnt_run;

  pd_state_e state_q, state_d;
  pd_cause_e cause_q, cause_d;
  logic      cause_en;
  logic      hiz_q, hiz_d;
  logic      hiz_en;
  pd_out_t   dec;

  assign rst_any = por_i | mrst_i;

  pwrdn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  pwrdn_wake_arb u_wake_arb (
    .state_i   (state_q),
    .irq_i     (irq_i),
    .dma_err_i (dma_err_i),
    .nmi_i     (nmi_i),
    .rst_req_i (rst_any),
    .wake_o    (wake),
    .cause_o   (wake_cause)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cause_d  = wake_cause;
    cause_en = 1'b0;
    hiz_d    = hiz_sel_i;
    hiz_en   = 1'b0;
    cnt_load = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (wake) begin
          state_d  = ST_EXC;
          cause_en = 1'b1;
        end else if (sleep_req_i) begin
          if (deep_sel_i) begin
            state_d = ST_STBY;
            hiz_en  = 1'b1;
          end else begin
            state_d = ST_SLEEP;
          end
        end
      end
      ST_SLEEP: begin
        if (wake) begin
          state_d  = ST_EXC;
          cause_en = 1'b1;
        end
      end
      ST_STBY: begin
        if (wake) begin
          state_d  = ST_SETTLE;
          cause_en = 1'b1;
          cnt_load = 1'b1;
        end
      end
      ST_SETTLE: begin
        cause_en = wake;
        if (cnt_zero) state_d = ST_EXC;
      end
      ST_EXC: begin
        if (wake) cause_en = 1'b1;
        else      state_d  = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  assign cnt_run = (state_q == ST_SETTLE);

  // State registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       cause_q <= CAUSE_IRQ;
    else if (cause_en) cause_q <= cause_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)     hiz_q <= 1'b0;
    else if (hiz_en) hiz_q <= hiz_d;
  end

  pwrdn_settle_cnt #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (cnt_load),
    .run_i  (cnt_run),
    .zero_o (cnt_zero)
  );

  pwrdn_out_dec u_out_dec (
    .state_i (state_q),
    .cause_i (cause_q),
    .hiz_i   (hiz_q),
    .out_o   (dec)
  );

  assign cpu_clk_en_o = dec.cpu_clk_en;
  assign per_clk_en_o = dec.per_clk_en;
  assign osc_en_o     = dec.osc_en;
  assign per_rst_o    = dec.per_rst;
  assign io_hiz_o     = dec.io_hiz;
  assign rst_hold_o   = dec.rst_hold;
  assign exc_entry_o  = dec.exc_entry;
  assign exc_cause_o  = dec.exc_cause;
  assign status_o     = dec.status;

  // R2
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_req_i && !deep_sel_i && !rst_any)
      |=> (status_o == 2'd1 && !cpu_clk_en_o && osc_en_o));

  // R3
  stby_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_req_i && deep_sel_i && !rst_any)
      |=> (status_o == 2'd2 && !osc_en_o && per_rst_o));

  // R6
  stby_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_STBY && !nmi_i && !rst_any) |=> (state_q == ST_STBY));

  // R7
  settle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_SETTLE && !cnt_zero) |=> (state_q == ST_SETTLE));

  // R9
  exc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (exc_entry_o && !rst_any) |=> (!exc_entry_o && status_o == 2'd0));

  // R10
  rst_first_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_RUN && rst_any) |=> (exc_entry_o && exc_cause_o == 2'd3));

  // R4
  hiz_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_SLEEP || state_q == ST_RUN) |-> !io_hiz_o);

endmodule

// File: tb/pwrdn_ctrl_tb.sv
module pwrdn_ctrl_tb_top;

  localparam int unsigned ST_N = 16;
  localparam int NVEC = 13;
  // fields: deep, hiz, por mrst nmi irq dma, expect wake, expect cause[1:0], expect settle
  localparam logic [10:0] VEC [NVEC] = '{
    11'b0_0_00010_1_00_0,
    11'b0_0_00001_1_01_0,
    11'b0_0_00100_1_10_0,
    11'b0_0_10000_1_11_0,
    11'b0_0_01000_1_11_0,
    11'b0_0_00111_1_10_0,
    11'b0_0_00011_1_00_0,
    11'b1_0_00010_0_00_0,
    11'b1_1_00001_0_00_0,
    11'b1_1_00100_1_10_1,
    11'b1_0_01000_1_11_1,
    11'b1_0_00110_1_10_1,
    11'b0_0_00000_0_00_0
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic sleep_req, deep_sel, hiz_sel, irq, dma_err, nmi, por, mrst;
  logic cpu_clk_en, per_clk_en, osc_en, per_rst, io_hiz, rst_hold, exc_entry;
  logic [1:0] exc_cause, status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwrdn_ctrl #(.SETTLE_CYCLES(ST_N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_req), .deep_sel_i(deep_sel),
    .hiz_sel_i(hiz_sel), .irq_i(irq), .dma_err_i(dma_err), .nmi_i(nmi),
    .por_i(por), .mrst_i(mrst), .cpu_clk_en_o(cpu_clk_en), .per_clk_en_o(per_clk_en),
    .osc_en_o(osc_en), .per_rst_o(per_rst), .io_hiz_o(io_hiz), .rst_hold_o(rst_hold),
    .exc_entry_o(exc_entry), .exc_cause_o(exc_cause), .status_o(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    sleep_req = 0; irq = 0; dma_err = 0; nmi = 0; por = 0; mrst = 0;
  endtask

  task automatic back_to_run();
    por = 1'b1;
    step();
    por = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (status == 2'd0 && !exc_entry) break;
      step();
    end
  endtask

  task automatic enter(input logic d, input logic h);
    sleep_req = 1'b1; deep_sel = d; hiz_sel = h;
    step();
    sleep_req = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; deep_sel = 0; hiz_sel = 0;
    clear_in();
    repeat (3) step();
    rst_ni = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 status", status, 0);
    chk("R1 clocks", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    chk("R1 quiet", {per_rst, io_hiz, rst_hold, exc_entry}, 4'b0000);

    for (int v = 0; v < NVEC; v++) begin
      logic [10:0] e;
      int n3;
      e = VEC[v];
      enter(e[10], e[9]);
      if (e[10]) begin
        chk("R3 status", status, 2);
        chk("R3 enables", {cpu_clk_en, per_clk_en, osc_en, per_rst}, 4'b0001);
        chk("R4 hiz standby", io_hiz, e[9]);
      end else begin
        chk("R2 status", status, 1);
        chk("R2 enables", {cpu_clk_en, per_clk_en, osc_en, per_rst}, 4'b0110);
        chk("R4 hiz sleep", io_hiz, 0);
      end
      {por, mrst, nmi, irq, dma_err} = e[8:4];
      step();
      clear_in();
      if (!e[3]) begin
        chk(e[10] ? "R6 stays standby" : "R5 stays sleep", status, e[10] ? 2 : 1);
        chk("R6 osc", osc_en, e[10] ? 0 : 1);
        chk("R6 no exc", exc_entry, 0);
        back_to_run();
      end else begin
        if (e[0]) begin
          n3 = 0;
          chk("R7 settle enables", {cpu_clk_en, per_clk_en, osc_en, per_rst}, 4'b0011);
          chk("R4 hiz settle", io_hiz, e[9]);
          chk("R8 hold", rst_hold, (e[2:1] == 2'd3) ? 1 : 0);
          while (status == 2'd3 && n3 < 100) begin
            n3++;
            step();
          end
          chk("R7 settle length", n3, ST_N);
        end
        chk("R9 exc pulse", exc_entry, 1);
        chk(e[0] ? "R7 cause" : "R5 cause", exc_cause, e[2:1]);
        step();
        chk("R9 pulse ends", exc_entry, 0);
        chk("R9 back to run", status, 0);
        chk("R9 cause idle", exc_cause, 0);
      end
    end

    // R10 reset wins over a sleep request in the same cycle
    sleep_req = 1; deep_sel = 1; por = 1;
    step();
    clear_in();
    chk("R10 no power-down", exc_entry, 1);
    chk("R10 cause reset", exc_cause, 3);
    step();
    chk("R10 run after", status, 0);

    // R11 sleep request while asleep has no effect
    enter(1'b0, 1'b1);
    sleep_req = 1; deep_sel = 1; hiz_sel = 1;
    step();
    sleep_req = 0;
    chk("R11 still sleep", status, 1);
    chk("R11 osc on", osc_en, 1);
    chk("R11 no hiz", io_hiz, 0);
    back_to_run();

    // R11 while in standby
    enter(1'b1, 1'b0);
    sleep_req = 1; deep_sel = 0; hiz_sel = 1;
    step();
    sleep_req = 0;
    chk("R11 still standby", status, 2);
    chk("R11 hiz kept", io_hiz, 0);

    // R12 reset partway through an NMI settle
    begin
      int n3;
      nmi = 1;
      step();
      nmi = 0;
      n3 = 0;
      chk("R12 nmi settle no hold", rst_hold, 0);
      repeat (5) begin n3++; step(); end
      mrst = 1;
      n3++;
      step();
      mrst = 0;
      chk("R12 hold raised", rst_hold, 1);
      chk("R12 still settle", status, 3);
      while (status == 2'd3 && n3 < 100) begin
        n3++;
        step();
      end
      chk("R12 total settle", n3, ST_N);
      chk("R12 cause reset", exc_cause, 3);
      chk("R12 exc pulse", exc_entry, 1);
      step();
      chk("R12 run", status, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule